// File: doc/BRIEF.md
# Three-Level Leg Carrier-Comparison Modulator

This block produces the four primary switch commands for one leg of a three-level inverter whose middle level is tied to the DC-link midpoint. It runs two triangular carriers in adjacent bands, one above zero and one below, with the lower carrier always the mirror image of the upper one. On every clock it compares a signed voltage command against both carriers. The outer switches follow those comparisons. Each inner switch is the complement of the outer switch on the opposite side.

The four switch commands and a two-bit output level code are registered. A change in the command or the carrier shows at the outputs one clock later. The command is clipped to the carrier range before it is compared, so any out-of-range value saturates to full-scale high or low. Current-polarity gating and dead-time insertion belong to the next stage and are not part of this block.

Top module: `npc_pod_modulator`

## Requirements
- R1: After reset the upper carrier is 1 and rising. It moves by exactly 1 per clock, turns down after reaching AMP and turns up after reaching 1. One period is 2*(AMP-1) clocks.
- R2: The lower carrier always equals the two's-complement negation of the upper carrier, so it spans -AMP to -1.
- R3: Switch bit 0 (outer high switch) goes high one clock after an edge at which the clipped command was greater than or equal to the upper carrier. Otherwise it goes low.
- R4: Switch bit 3 (outer low switch) goes high one clock after an edge at which the clipped command was less than or equal to the lower carrier. Otherwise it goes low.
- R5: Switch bit 1 (inner high switch) is always the inverse of bit 3, and switch bit 2 (inner low switch) is always the inverse of bit 0.
- R6: The level code is 2'b10 when bit 0 is high (positive level: bits 0 and 1 on), 2'b01 when bit 3 is high (negative level: bits 2 and 3 on), and 2'b00 otherwise (middle level: bits 1 and 2 on). Bits 0 and 3 are never high together.
- R7: A command above AMP acts exactly like AMP, and a command below -AMP acts exactly like -AMP. This includes the most negative code.
- R8: While reset is held and right after it, the switch bits read 4'b0110 and the level code reads 2'b00.
- R9: A zero command holds the middle level on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vcmd_i | input | CMD_W | Signed two's-complement voltage command |
| car_up_o | output | CMD_W | Upper carrier, signed, 1..AMP |
| car_dn_o | output | CMD_W | Lower carrier, signed, -AMP..-1 |
| sw_o | output | 4 | Switch commands: bit0 outer high, bit1 inner high, bit2 inner low, bit3 outer low |
| lvl_o | output | 2 | Output level: 10 positive, 00 middle, 01 negative |

## Verification
Two events can land in the same clock: the upper carrier turning at its peak or trough, and the command crossing that carrier. The bench provokes this by holding the command at exactly AMP and exactly 1, and by sweeping the command by one step per clock while the carrier also moves. At each edge the bench records the carrier value it observes and the command it drives. One clock later it judges both outer switches against its own model of the carrier sequence and the clipped command.

// File: rtl/npc_pod_pkg.sv
package npc_pod_pkg;

    typedef enum logic [1:0] {
        LVL_MID = 2'b00,
        LVL_NEG = 2'b01,
        LVL_POS = 2'b10
    } leg_level_e;

endpackage

// File: rtl/pod_tri_carrier.sv
module pod_tri_carrier #(
    parameter int CMD_W = 16,
    parameter int AMP   = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic signed [CMD_W-1:0] up_o,
    output logic signed [CMD_W-1:0] dn_o
);

    localparam logic signed [CMD_W-1:0] PEAK = CMD_W'(AMP);
    localparam logic signed [CMD_W-1:0] ONE  = CMD_W'(1);

    typedef struct packed {
        logic signed [CMD_W-1:0] cnt;
        logic                    falling;
    } car_state_t;

    car_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.falling) begin
            if (st_q.cnt >= PEAK) begin
                st_d.falling = 1'b1;
                st_d.cnt     = st_q.cnt - ONE;
            end else begin
                st_d.cnt     = st_q.cnt + ONE;
            end
        end else begin
            if (st_q.cnt <= ONE) begin
                st_d.falling = 1'b0;
                st_d.cnt     = st_q.cnt + ONE;
            end else begin
                st_d.cnt     = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt     <= ONE;
            st_q.falling <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign up_o = st_q.cnt;
    assign dn_o = -st_q.cnt;

    assert_carrier_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt >= ONE) && (st_q.cnt <= PEAK));

    assert_carrier_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.falling && st_q.cnt < PEAK) |=> (st_q.cnt == $past(st_q.cnt) + ONE));

    assert_carrier_peak_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == PEAK) |=> (st_q.cnt == PEAK - ONE));

    assert_carrier_trough_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.falling && st_q.cnt == ONE) |=> (st_q.cnt == ONE + ONE));

endmodule

// File: rtl/pod_cmd_clip.sv
module pod_cmd_clip #(
    parameter int CMD_W = 16,
    parameter int AMP   = 100
) (
    input  logic signed [CMD_W-1:0] cmd_i,
    output logic signed [CMD_W-1:0] cmd_o
);

    localparam logic signed [CMD_W-1:0] PEAK = CMD_W'(AMP);
    localparam logic signed [CMD_W-1:0] FLOOR = -PEAK;

    always_comb begin
        if (cmd_i > PEAK) begin
            cmd_o = PEAK;
        end else if (cmd_i < FLOOR) begin
            cmd_o = FLOOR;
        end else begin
            cmd_o = cmd_i;
        end
    end

endmodule

// File: rtl/pod_leg_compare.sv
module pod_leg_compare
    import npc_pod_pkg::*;
#(
    parameter int CMD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [CMD_W-1:0] cmd_i,
    input  logic signed [CMD_W-1:0] car_up_i,
    input  logic signed [CMD_W-1:0] car_dn_i,
    output logic                    hi_o,
    output logic                    lo_o,
    output leg_level_e              lvl_o
);

    typedef struct packed {
        logic       hi;
        logic       lo;
        leg_level_e lvl;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    always_comb begin
        st_d.hi = (cmd_i >= car_up_i);
        st_d.lo = (cmd_i <= car_dn_i);
        if (st_d.hi) begin
            st_d.lvl = LVL_POS;
        end else if (st_d.lo) begin
            st_d.lvl = LVL_NEG;
        end else begin
            st_d.lvl = LVL_MID;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hi  <= 1'b0;
            st_q.lo  <= 1'b0;
            st_q.lvl <= LVL_MID;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_o  = st_q.hi;
    assign lo_o  = st_q.lo;
    assign lvl_o = st_q.lvl;

    assert_hi_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i >= car_up_i) |=> st_q.hi);

    assert_lo_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i <= car_dn_i) |=> st_q.lo);

    assert_outer_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.hi && st_q.lo));

endmodule

// File: rtl/npc_pod_modulator.sv
module npc_pod_modulator
    import npc_pod_pkg::*;
#(
    parameter int CMD_W = 16,
    parameter int AMP   = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] vcmd_i,
    output logic [CMD_W-1:0] car_up_o,
    output logic [CMD_W-1:0] car_dn_o,
    output logic [3:0]       sw_o,
    output logic [1:0]       lvl_o
);

    localparam logic signed [CMD_W-1:0] PEAK = CMD_W'(AMP);

    logic signed [CMD_W-1:0] car_up, car_dn, cmd_clip;
    logic                    hi, lo;
    leg_level_e              lvl;

    pod_tri_carrier #(.CMD_W(CMD_W), .AMP(AMP)) u_carrier (
        .clk   (clk),
        .rst_n (rst_n),
        .up_o  (car_up),
        .dn_o  (car_dn)
    );

    pod_cmd_clip #(.CMD_W(CMD_W), .AMP(AMP)) u_clip (
        .cmd_i (signed'(vcmd_i)),
        .cmd_o (cmd_clip)
    );

    pod_leg_compare #(.CMD_W(CMD_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd_clip),
        .car_up_i (car_up),
        .car_dn_i (car_dn),
        .hi_o     (hi),
        .lo_o     (lo),
        .lvl_o    (lvl)
    );

    assign car_up_o = car_up;
    assign car_dn_o = car_dn;
    assign sw_o     = {lo, ~hi, ~lo, hi};
    assign lvl_o    = lvl;

    assert_clip_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (signed'(vcmd_i) > PEAK) |=> (sw_o[0] && lvl_o == 2'b10));

    assert_clip_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (signed'(vcmd_i) < -PEAK) |=> (sw_o[3] && lvl_o == 2'b01));

    assert_zero_mid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vcmd_i == '0) |=> (sw_o == 4'b0110));

endmodule

// File: tb/npc_pod_modulator_test.sv
`timescale 1ns/1ps
module npc_pod_modulator_test;

    localparam int CMD_W = 8;
    localparam int AMP   = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CMD_W-1:0] vcmd = '0;
    logic [CMD_W-1:0] car_up, car_dn;
    logic [3:0]       sw;
    logic [1:0]       lvl;

    int checks = 0;
    int errors = 0;
    int exp_car = 1;
    bit exp_fall = 1'b0;

    always #2.5 clk = ~clk;

    npc_pod_modulator #(.CMD_W(CMD_W), .AMP(AMP)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .vcmd_i   (vcmd),
        .car_up_o (car_up),
        .car_dn_o (car_dn),
        .sw_o     (sw),
        .lvl_o    (lvl)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    function automatic int clip(input int c);
        if (c > AMP) return AMP;
        if (c < -AMP) return -AMP;
        return c;
    endfunction

    // one clock: drive at negedge, judge outputs at following negedge
    task automatic step(input int cmd, input string tag);
        int c, cu, cd;
        bit e1, e4;
        int elvl;
        vcmd = CMD_W'(cmd);
        cu = int'($signed(car_up));
        cd = int'($signed(car_dn));
        chk(cu == exp_car, {"R1 upper carrier ", tag}, cu, exp_car);
        chk(cd == -exp_car, {"R2 lower carrier ", tag}, cd, -exp_car);
        c  = clip(cmd);
        e1 = (c >= exp_car);
        e4 = (c <= -exp_car);
        elvl = e1 ? 2 : (e4 ? 1 : 0);
        @(negedge clk);
        chk(sw[0] == e1, {"R3 outer high ", tag}, int'(sw[0]), int'(e1));
        chk(sw[3] == e4, {"R4 outer low ", tag}, int'(sw[3]), int'(e4));
        chk(sw[1] == ~sw[3] && sw[2] == ~sw[0], {"R5 inner pair ", tag}, int'(sw), int'({e4, ~e1, ~e4, e1}));
        chk(int'(lvl) == elvl, {"R6 level ", tag}, int'(lvl), elvl);
        if (!exp_fall) begin
            if (exp_car >= AMP) begin exp_fall = 1'b1; exp_car--; end
            else exp_car++;
        end else begin
            if (exp_car <= 1) begin exp_fall = 1'b0; exp_car++; end
            else exp_car--;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sw == 4'b0110, "R8 switches in reset", int'(sw), 6);
        chk(lvl == 2'b00, "R8 level in reset", int'(lvl), 0);
        rst_n = 1'b1;
        chk(sw == 4'b0110, "R8 switches after release", int'(sw), 6);
        chk(int'($signed(car_up)) == 1, "R1 carrier after reset", int'($signed(car_up)), 1);
    endtask

    task automatic t_zero();
        for (int i = 0; i < 2 * (AMP - 1) + 2; i++) begin
            step(0, "R9 zero");
            chk(sw == 4'b0110 && lvl == 2'b00, "R9 zero holds middle", int'(sw), 6);
        end
    endtask

    task automatic t_hold(input int cmd, input string tag);
        for (int i = 0; i < 2 * (AMP - 1); i++) step(cmd, tag);
    endtask

    task automatic t_clip();
        for (int i = 0; i < 2 * (AMP - 1); i++) begin
            step(127, "R7 max code");
            chk(sw[0] == 1'b1, "R7 max code is positive", int'(sw[0]), 1);
        end
        for (int i = 0; i < 2 * (AMP - 1); i++) begin
            step(-128, "R7 min code");
            chk(sw[3] == 1'b1, "R7 min code is negative", int'(sw[3]), 1);
        end
        step(AMP + 1, "R7 just above");
        step(-AMP - 1, "R7 just below");
    endtask

    task automatic t_sweep();
        for (int v = -AMP - 2; v <= AMP + 2; v++) step(v, "sweep up");
        for (int v = AMP + 2; v >= -AMP - 2; v -= 3) step(v, "sweep down");
    endtask

    initial begin : watchdog
        #(5ns * 50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        t_zero();
        t_hold(6, "mid positive");
        t_hold(-5, "mid negative");
        t_hold(AMP, "at peak");
        t_hold(1, "at trough");
        t_hold(-AMP, "at negative peak");
        t_hold(-1, "at negative trough");
        t_clip();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule